// File: doc/BRIEF.md
# Target Address Resolver and Matcher

This block sets the 7-bit target address that a device answers to on a two-wire management bus and checks each incoming address byte against it. The address is built from two sources. One is a 7-bit value held in non-volatile configuration. The other is a 4-bit value from a strap-pin decoder, which comes with a flag that says the strap pin is left floating. When the strap is driven, its value sets the low four bits of the address and the stored value sets the rest. When the strap floats, the stored value is used whole. No software path can alter the strap-derived bits.

The resolved address is captured on the first clock after reset is released, and again whenever the reload strobe pulses. Between those events it holds still, whatever the configuration inputs do. The bus front end hands over each captured address byte together with a one-cycle valid strobe. The block then raises a one-cycle hit pulse if the byte addresses this device or either of the two broadcast addresses, 0x5A and 0x5B, which every device must accept. A second output tells a broadcast hit apart from an own-address hit. A configuration-conflict flag is raised when the resolved own address falls on one of the broadcast addresses.

Top module: `addr_matcher`

## Requirements
- R1: With `strap_float` low, bits [3:0] of the resolved address equal `strap_val`, whatever the stored address holds in those bits.
- R2: Bits [6:4] of the resolved address always equal bits [6:4] of `cfg_addr` as sampled at load time.
- R3: With `strap_float` high, the resolved address equals `cfg_addr` unchanged.
- R4: A valid address byte whose bits [7:1] equal 0x5A or 0x5B gives a hit with `hit_global` high, whatever the own address is.
- R5: The resolved address is loaded at the first rising edge after reset release and at every rising edge where `reload` is high. Changes on `cfg_addr`, `strap_val` or `strap_float` at any other time have no effect on `own_addr`.
- R6: `cfg_conflict` is high exactly when the loaded own address is 0x5A or 0x5B. It is updated together with `own_addr`.
- R7: `addr_hit` is high for exactly the one cycle after a cycle in which `addr_valid` is high and bits [7:1] of `addr_byte` match. Bit 0, the read/write bit, is ignored. Without `addr_valid` there is no hit.
- R8: `hit_global` is low for a hit on a non-broadcast own address, and it is low whenever `addr_hit` is low.
- R9: While reset is held, `own_addr`, `cfg_conflict`, `addr_hit` and `hit_global` are all zero.
- R10: If `reload` and `addr_valid` are high in the same cycle, the byte is compared against the address that was loaded before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 7 | Stored configuration address |
| strap_val | input | 4 | Decoded strap value |
| strap_float | input | 1 | High when the strap pin is floating |
| reload | input | 1 | Pulse to re-capture the resolved address |
| addr_byte | input | 8 | Captured address byte; bit 0 is the read/write bit |
| addr_valid | input | 1 | One-cycle strobe qualifying `addr_byte` |
| own_addr | output | 7 | Resolved own address |
| cfg_conflict | output | 1 | Own address equals a broadcast address |
| addr_hit | output | 1 | One-cycle match pulse |
| hit_global | output | 1 | Hit came from a broadcast address |

## Verification
The pulse assertions assume `addr_valid` is a single-cycle strobe per byte. The load assertions assume the configuration inputs are steady during the cycle in which `reload` is sampled. The bench drives every input at the falling edge and drops `addr_valid` and `reload` after one cycle, so both assumptions always hold. The random stimulus sends bytes aimed at the own address, at both broadcast addresses and at arbitrary values, each with a random read/write bit. It also scrambles the configuration inputs between reloads, which exercises the hold behaviour.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
    localparam int DEF_ADDR_W  = 7;
    localparam int DEF_STRAP_W = 4;
    localparam int DEF_NUM_GLB = 2;
    localparam logic [DEF_NUM_GLB-1:0][DEF_ADDR_W-1:0] DEF_GLB_LIST = {7'h5B, 7'h5A};

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_OWN    = 2'd1,
        SRC_GLOBAL = 2'd2
    } hit_src_e;
endpackage

// File: rtl/addr_resolve.sv
module addr_resolve #(
    parameter int ADDR_W  = 7,
    parameter int STRAP_W = 4,
    parameter int NUM_GLB = 2,
    parameter logic [NUM_GLB-1:0][ADDR_W-1:0] GLB_LIST = {7'h5B, 7'h5A}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [STRAP_W-1:0] strap_val,
    input  logic               strap_float,
    input  logic               reload,
    output logic [ADDR_W-1:0]  own_addr,
    output logic               cfg_conflict
);
    localparam int UPPER_W = ADDR_W - STRAP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] own;
        logic              conflict;
        logic              pend;
    } res_state_t;

    res_state_t st_d, st_q;
    logic [ADDR_W-1:0]  cand_d;
    logic [NUM_GLB-1:0] cand_glb_d;

    for (genvar g = 0; g < NUM_GLB; g++) begin : g_glb_cmp
        assign cand_glb_d[g] = (cand_d == GLB_LIST[g]);
    end

    always_comb begin
        cand_d = strap_float ? cfg_addr
                             : {cfg_addr[ADDR_W-1 -: UPPER_W], strap_val};
        st_d = st_q;
        if (st_q.pend || reload) begin
            st_d.own      = cand_d;
            st_d.conflict = |cand_glb_d;
            st_d.pend     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.own      <= '0;
            st_q.conflict <= 1'b0;
            st_q.pend     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign own_addr     = st_q.own;
    assign cfg_conflict = st_q.conflict;

    p_strap_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reload) && !$past(strap_float))
        |-> own_addr[STRAP_W-1:0] == $past(strap_val));

    p_upper_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reload))
        |-> own_addr[ADDR_W-1 -: UPPER_W] == $past(cfg_addr[ADDR_W-1 -: UPPER_W]));

    p_float_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reload) && $past(strap_float))
        |-> own_addr == $past(cfg_addr));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reload) && !$past(st_q.pend))
        |-> $stable(own_addr));

    p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reload) && $past(cand_glb_d) == '0)
        |-> !cfg_conflict);
endmodule

// File: rtl/addr_compare.sv
module addr_compare
    import addr_match_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_GLB = 2,
    parameter logic [NUM_GLB-1:0][ADDR_W-1:0] GLB_LIST = {7'h5B, 7'h5A}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   addr_byte,
    input  logic              addr_valid,
    output logic              addr_hit,
    output logic              hit_global
);
    typedef struct packed {
        hit_src_e src;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [ADDR_W-1:0]  rx_addr_d;
    logic [NUM_GLB-1:0] glb_eq_d;
    logic               own_eq_d;

    assign rx_addr_d = addr_byte[ADDR_W:1];

    for (genvar g = 0; g < NUM_GLB; g++) begin : g_glb_cmp
        assign glb_eq_d[g] = (rx_addr_d == GLB_LIST[g]);
    end

    assign own_eq_d = (rx_addr_d == own_addr);

    always_comb begin
        st_d.src = SRC_NONE;
        if (addr_valid) begin
            if (|glb_eq_d)     st_d.src = SRC_GLOBAL;
            else if (own_eq_d) st_d.src = SRC_OWN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.src <= SRC_NONE;
        else        st_q     <= st_d;
    end

    assign addr_hit   = (st_q.src != SRC_NONE);
    assign hit_global = (st_q.src == SRC_GLOBAL);

    p_no_valid_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !addr_hit);

    p_own_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_byte[ADDR_W:1] == own_addr) |=> addr_hit);

    p_global_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && |glb_eq_d) |=> (addr_hit && hit_global));

    p_global_implies_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_global |-> addr_hit);
endmodule

// File: rtl/addr_matcher.sv
module addr_matcher
    import addr_match_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int STRAP_W = DEF_STRAP_W,
    parameter int NUM_GLB = DEF_NUM_GLB,
    parameter logic [NUM_GLB-1:0][ADDR_W-1:0] GLB_LIST = DEF_GLB_LIST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [STRAP_W-1:0] strap_val,
    input  logic               strap_float,
    input  logic               reload,
    input  logic [ADDR_W:0]    addr_byte,
    input  logic               addr_valid,
    output logic [ADDR_W-1:0]  own_addr,
    output logic               cfg_conflict,
    output logic               addr_hit,
    output logic               hit_global
);
    logic [ADDR_W-1:0] own_addr_q;

    addr_resolve #(
        .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .NUM_GLB(NUM_GLB), .GLB_LIST(GLB_LIST)
    ) u_resolve (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .strap_val(strap_val),
        .strap_float(strap_float), .reload(reload),
        .own_addr(own_addr_q), .cfg_conflict(cfg_conflict)
    );

    addr_compare #(
        .ADDR_W(ADDR_W), .NUM_GLB(NUM_GLB), .GLB_LIST(GLB_LIST)
    ) u_compare (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr_q), .addr_byte(addr_byte),
        .addr_valid(addr_valid), .addr_hit(addr_hit), .hit_global(hit_global)
    );

    assign own_addr = own_addr_q;

    p_reset_clear_r9: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) |-> (!addr_hit && !hit_global && !cfg_conflict));

    p_old_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && addr_valid && reload && addr_byte[ADDR_W:1] == own_addr_q)
        |=> addr_hit);
endmodule

// File: tb/addr_matcher_test.sv
module addr_matcher_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [3:0] strap_val = '0;
    logic       strap_float = 1'b0;
    logic       reload = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       addr_valid = 1'b0;
    logic [6:0] own_addr;
    logic       cfg_conflict, addr_hit, hit_global;

    int checks = 0;
    int errors = 0;
    logic [6:0] own_exp;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_matcher uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .strap_val(strap_val),
        .strap_float(strap_float), .reload(reload), .addr_byte(addr_byte),
        .addr_valid(addr_valid), .own_addr(own_addr), .cfg_conflict(cfg_conflict),
        .addr_hit(addr_hit), .hit_global(hit_global)
    );

    function automatic logic [6:0] exp_resolve(logic [6:0] c, logic [3:0] s, logic f);
        return f ? c : {c[6:4], s};
    endfunction

    function automatic logic exp_glb(logic [6:0] a);
        return (a == 7'h5A) || (a == 7'h5B);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [6:0] c, logic [3:0] s, logic f, string req);
        @(negedge clk);
        cfg_addr = c; strap_val = s; strap_float = f; reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        own_exp = exp_resolve(c, s, f);
        chk(req, own_addr, own_exp);
        chk("R6", cfg_conflict, exp_glb(own_exp));
    endtask

    task automatic send(logic [7:0] b, string req);
        logic g, h;
        @(negedge clk);
        addr_byte = b; addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        g = exp_glb(b[7:1]);
        h = g || (b[7:1] == own_exp);
        chk(req, addr_hit, h);
        chk("R8", hit_global, g);
        @(negedge clk);
        chk("R7", addr_hit, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        cfg_addr = 7'h35; strap_val = 4'h9; strap_float = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", own_addr, 7'h0);
        chk("R9", cfg_conflict, 1'b0);
        chk("R9", addr_hit, 1'b0);
        chk("R9", hit_global, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        own_exp = exp_resolve(7'h35, 4'h9, 1'b0);
        chk("R5", own_addr, own_exp);
        chk("R1", own_addr[3:0], 4'h9);
        chk("R2", own_addr[6:4], 3'h3);

        // R5: input changes without reload are ignored
        @(negedge clk);
        cfg_addr = 7'h12; strap_val = 4'h1; strap_float = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5", own_addr, own_exp);

        // R3: floating strap
        do_load(7'h6C, 4'h2, 1'b1, "R3");
        send({7'h6C, 1'b1}, "R7");
        send({7'h6C, 1'b0}, "R7");
        send({7'h6D, 1'b0}, "R7");

        // R4: broadcast addresses
        send({7'h5A, 1'b0}, "R4");
        send({7'h5B, 1'b1}, "R4");

        // R7: no valid, no hit
        @(negedge clk);
        addr_byte = {7'h6C, 1'b0};
        @(negedge clk);
        chk("R7", addr_hit, 1'b0);

        // R6: conflict through strap
        do_load(7'h50, 4'hA, 1'b0, "R1");
        chk("R6", cfg_conflict, 1'b1);
        send({7'h5A, 1'b0}, "R4");
        do_load(7'h5B, 4'h0, 1'b1, "R3");
        chk("R6", cfg_conflict, 1'b1);
        do_load(7'h21, 4'h7, 1'b0, "R1");
        chk("R6", cfg_conflict, 1'b0);

        // R10: reload with a simultaneous byte uses the old address
        @(negedge clk);
        cfg_addr = 7'h44; strap_val = 4'h4; strap_float = 1'b1; reload = 1'b1;
        addr_byte = {7'h27, 1'b0}; addr_valid = 1'b1;
        @(negedge clk);
        reload = 1'b0; addr_valid = 1'b0;
        chk("R10", addr_hit, 1'b1);
        chk("R10", own_addr, 7'h44);
        own_exp = 7'h44;

        // random
        for (int i = 0; i < 300; i++) begin
            int unsigned k;
            logic [6:0] a;
            k = $urandom_range(0, 9);
            if (k == 0) begin
                do_load(7'($urandom), 4'($urandom), 1'($urandom), "R2");
            end else begin
                if (k < 4)      a = own_exp;
                else if (k < 5) a = 7'h5A;
                else if (k < 6) a = 7'h5B;
                else            a = 7'($urandom);
                if (k == 9) begin
                    @(negedge clk);
                    cfg_addr = 7'($urandom); strap_val = 4'($urandom);
                    strap_float = 1'($urandom);
                end
                send({a, 1'($urandom)}, "R7");
                chk("R5", own_addr, own_exp);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule